// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block keeps a small set of recent page translations, eight by default, in front of a page table. A lookup presents a virtual page number and an access kind. Every stored entry is compared with it in the same cycle. On a hit the block answers with the frame number after it has checked the access against the entry's read, write and execute permissions. A permitted write marks the entry as dirty.

On a miss the block stalls, asks an external page-table walker for the entry, and installs the returned fields into a victim slot. When the victim slot held a live translation, that translation's page number and dirty flag are reported so the page table can be updated. If the walker says the page is not resident, a page fault is reported and nothing is installed. A separate flush input removes the entry for one page, so that a change of permissions in the page table takes effect on the next lookup.

Top module: `fa_tlb`

## Requirements
- R1: After reset every entry is invalid, `req_ready` is 1, and `resp_valid`, `walk_req` and `wb_valid` are 0.
- R2: A lookup is accepted in a cycle with `req_valid` and `req_ready` both high. If a valid entry holds the same page number, `resp_valid` is 1 in the next cycle and no walk is started.
- R3: Access kinds are 0 read, 1 write, 2 execute, and 3 is treated as read. The permission field is {read, write, execute} in bits [2:0]. An access without its permission gives `resp_prot_fault`=1 and `resp_pfn`=0. A permitted access gives the entry's frame on `resp_pfn` with both fault flags 0.
- R4: A permitted write sets the entry's dirty flag, whether it hits or is installed by a walk. A denied write leaves the flag unchanged.
- R5: On a miss, `walk_req` rises in the next cycle with the page number on `walk_vpn`. It stays high until the cycle in which `walk_rsp_valid` is seen. `req_ready` is 0 throughout, so no new lookup is accepted.
- R6: A walk response with `walk_rsp_present`=1 installs the page number, frame, permissions and dirty flag. In the next cycle `resp_valid` is 1, the result is judged with the fetched permissions, and `req_ready` is 1 again.
- R7: A walk response with `walk_rsp_present`=0 gives `resp_valid`=1 and `resp_page_fault`=1 in the next cycle and installs nothing, so a repeat lookup misses again.
- R8: The victim is the lowest-numbered invalid entry. When all entries are valid, a rotating pointer picks the victim. The pointer starts at 0 after reset and advances by one, wrapping, on each such use.
- R9: Evicting a valid entry raises `wb_valid` in the same cycle as the response, with the evicted page on `wb_vpn` and its dirty flag on `wb_dirty`.
- R10: A flush invalidates the entry whose page number equals `flush_vpn`, at the end of that cycle. A lookup in the same cycle still sees the old contents. A flush wins over a dirty update to the same entry, and an entry installed in the same cycle is not removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_kind | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| req_ready | output | 1 | Lookup can be accepted |
| resp_valid | output | 1 | Result available |
| resp_pfn | output | PFN_W | Frame number, 0 on a fault |
| resp_prot_fault | output | 1 | Access not permitted |
| resp_page_fault | output | 1 | Page not resident |
| walk_req | output | 1 | Page-table entry wanted |
| walk_vpn | output | VPN_W | Page number being fetched |
| walk_rsp_valid | input | 1 | Walker answer |
| walk_rsp_present | input | 1 | Fetched entry is resident |
| walk_rsp_pfn | input | PFN_W | Fetched frame number |
| walk_rsp_perm | input | 3 | Fetched permissions {read, write, execute} |
| wb_valid | output | 1 | Evicted translation reported |
| wb_vpn | output | VPN_W | Page number of evicted entry |
| wb_dirty | output | 1 | Dirty flag of evicted entry |
| flush_valid | input | 1 | Flush request |
| flush_vpn | input | VPN_W | Page number to remove |

## Verification
A flush can land in the same cycle as a lookup of the same page, and it can also arrive while a walk is pending. The bench drives a flush of page 5 together with a write lookup of page 5. It expects a hit answer from the old entry, with no dirty update, and then a fresh walk on the next lookup of that page. In the random phase, flushes are scattered across lookup and walk cycles. A behavioural model with plain arrays predicts every output on every clock, including which victim is reported.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } tlb_state_e;

    function automatic logic perm_allows(perm_t p, acc_kind_e k);
        case (k)
            ACC_WRITE: return p.wr;
            ACC_EXEC:  return p.ex;
            default:   return p.rd;
        endcase
    endfunction

endpackage

// File: rtl/fa_tlb_cam.sv
module fa_tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [PFN_W-1:0]   hit_pfn,
    output perm_t              hit_perm,
    input  logic               mod_set,
    input  logic [IDX_W-1:0]   mod_idx,
    input  logic               flush_en,
    input  logic [VPN_W-1:0]   flush_vpn,
    input  logic               ins_en,
    input  logic [IDX_W-1:0]   ins_idx,
    input  logic [VPN_W-1:0]   ins_vpn,
    input  logic [PFN_W-1:0]   ins_pfn,
    input  perm_t              ins_perm,
    input  logic               ins_mod,
    input  logic [IDX_W-1:0]   vic_idx,
    output logic               vic_valid,
    output logic [VPN_W-1:0]   vic_vpn,
    output logic               vic_mod,
    output logic [ENTRIES-1:0] valid_vec
);

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] mod_q;
    logic [ENTRIES-1:0] match;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [PFN_W-1:0]   pfn_q  [ENTRIES];
    perm_t              perm_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic load_here;
        logic flush_here;
        assign load_here  = ins_en && (ins_idx == IDX_W'(g));
        assign flush_here = flush_en && valid_q[g] && (vpn_q[g] == flush_vpn);
        assign match[g]   = valid_q[g] && (vpn_q[g] == lk_vpn);

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g] <= 1'b0;
                mod_q[g]   <= 1'b0;
            end else if (load_here) begin
                valid_q[g] <= 1'b1;
                vpn_q[g]   <= ins_vpn;
                pfn_q[g]   <= ins_pfn;
                perm_q[g]  <= ins_perm;
                mod_q[g]   <= ins_mod;
            end else if (flush_here) begin
                valid_q[g] <= 1'b0;
            end else if (mod_set && (mod_idx == IDX_W'(g))) begin
                mod_q[g]   <= 1'b1;
            end
        end
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit       = |match;
    assign hit_pfn   = pfn_q[hit_idx];
    assign hit_perm  = perm_q[hit_idx];
    assign vic_valid = valid_q[vic_idx];
    assign vic_vpn   = vpn_q[vic_idx];
    assign vic_mod   = mod_q[vic_idx];
    assign valid_vec = valid_q;

    // R2
    match_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    // R8
    install_target_chk: assert property (@(posedge clk) disable iff (rst)
        ins_en |=> valid_q[$past(ins_idx)]);

endmodule

// File: rtl/fa_tlb_victim.sv
module fa_tlb_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               advance,
    output logic [IDX_W-1:0]   vic_idx,
    output logic               full
);

    logic [IDX_W-1:0] rr_q;

    assign full = &valid_vec;

    always_comb begin
        vic_idx = rr_q;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) vic_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (advance && full) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    // R8
    free_slot_chk: assert property (@(posedge clk) disable iff (rst)
        !full |-> !valid_vec[vic_idx]);

endmodule

// File: rtl/fa_tlb.sv
module fa_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [1:0]       req_kind,
    output logic             req_ready,
    output logic             resp_valid,
    output logic [PFN_W-1:0] resp_pfn,
    output logic             resp_prot_fault,
    output logic             resp_page_fault,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             walk_rsp_valid,
    input  logic             walk_rsp_present,
    input  logic [PFN_W-1:0] walk_rsp_pfn,
    input  logic [2:0]       walk_rsp_perm,
    output logic             wb_valid,
    output logic [VPN_W-1:0] wb_vpn,
    output logic             wb_dirty,
    input  logic             flush_valid,
    input  logic [VPN_W-1:0] flush_vpn
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tlb_state_e         state_q;
    logic [VPN_W-1:0]   pend_vpn_q;
    acc_kind_e          pend_kind_q;
    acc_kind_e          kind;

    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [PFN_W-1:0]   hit_pfn;
    perm_t              hit_perm;
    logic               hit_ok;
    perm_t              rsp_perm;
    logic               rsp_ok;
    logic               accept;
    logic               mod_set;
    logic               ins_en;
    logic               ins_mod;
    logic [IDX_W-1:0]   vic_idx;
    logic               vic_valid;
    logic [VPN_W-1:0]   vic_vpn;
    logic               vic_mod;
    logic               full;
    logic [ENTRIES-1:0] valid_vec;

    assign kind      = acc_kind_e'(req_kind);
    assign rsp_perm  = perm_t'(walk_rsp_perm);
    assign hit_ok    = perm_allows(hit_perm, kind);
    assign rsp_ok    = perm_allows(rsp_perm, pend_kind_q);
    assign req_ready = (state_q == ST_IDLE);
    assign walk_req  = (state_q == ST_WALK);
    assign walk_vpn  = pend_vpn_q;
    assign accept    = req_ready && req_valid;
    assign mod_set   = accept && hit && hit_ok && (kind == ACC_WRITE);
    assign ins_en    = walk_req && walk_rsp_valid && walk_rsp_present;
    assign ins_mod   = rsp_ok && (pend_kind_q == ACC_WRITE);

    fa_tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_cam (
        .clk       (clk),
        .rst       (rst),
        .lk_vpn    (req_vpn),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .hit_pfn   (hit_pfn),
        .hit_perm  (hit_perm),
        .mod_set   (mod_set),
        .mod_idx   (hit_idx),
        .flush_en  (flush_valid),
        .flush_vpn (flush_vpn),
        .ins_en    (ins_en),
        .ins_idx   (vic_idx),
        .ins_vpn   (pend_vpn_q),
        .ins_pfn   (walk_rsp_pfn),
        .ins_perm  (rsp_perm),
        .ins_mod   (ins_mod),
        .vic_idx   (vic_idx),
        .vic_valid (vic_valid),
        .vic_vpn   (vic_vpn),
        .vic_mod   (vic_mod),
        .valid_vec (valid_vec)
    );

    fa_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (valid_vec),
        .advance   (ins_en),
        .vic_idx   (vic_idx),
        .full      (full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q         <= ST_IDLE;
            pend_vpn_q      <= '0;
            pend_kind_q     <= ACC_READ;
            resp_valid      <= 1'b0;
            resp_pfn        <= '0;
            resp_prot_fault <= 1'b0;
            resp_page_fault <= 1'b0;
            wb_valid        <= 1'b0;
            wb_vpn          <= '0;
            wb_dirty        <= 1'b0;
        end else begin
            resp_valid      <= 1'b0;
            resp_pfn        <= '0;
            resp_prot_fault <= 1'b0;
            resp_page_fault <= 1'b0;
            wb_valid        <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (hit) begin
                            resp_valid      <= 1'b1;
                            resp_pfn        <= hit_ok ? hit_pfn : '0;
                            resp_prot_fault <= !hit_ok;
                        end else begin
                            state_q     <= ST_WALK;
                            pend_vpn_q  <= req_vpn;
                            pend_kind_q <= kind;
                        end
                    end
                end
                ST_WALK: begin
                    if (walk_rsp_valid) begin
                        state_q    <= ST_IDLE;
                        resp_valid <= 1'b1;
                        if (!walk_rsp_present) begin
                            resp_page_fault <= 1'b1;
                        end else begin
                            resp_pfn        <= rsp_ok ? walk_rsp_pfn : '0;
                            resp_prot_fault <= !rsp_ok;
                            wb_valid        <= vic_valid;
                            wb_vpn          <= vic_vpn;
                            wb_dirty        <= vic_mod;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R5
    walk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (walk_req && !walk_rsp_valid) |=> walk_req);

    // R5
    stall_while_walk_chk: assert property (@(posedge clk) disable iff (rst)
        walk_req |-> !req_ready);

    // R6
    walk_answer_chk: assert property (@(posedge clk) disable iff (rst)
        (walk_req && walk_rsp_valid) |=> (resp_valid && req_ready));

    // R3
    fault_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(resp_prot_fault && resp_page_fault));

    // R3
    fault_zero_pfn_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_prot_fault || resp_page_fault) |-> (resp_pfn == '0));

    // R9
    wb_with_resp_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (resp_valid && !resp_page_fault));

endmodule

// File: tb/fa_tlb_test.sv
module fa_tlb_test;

    localparam int N     = 8;
    localparam int VPN_W = 20;
    localparam int PFN_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [VPN_W-1:0] req_vpn = '0;
    logic [1:0]       req_kind = '0;
    logic             req_ready;
    logic             resp_valid;
    logic [PFN_W-1:0] resp_pfn;
    logic             resp_prot_fault;
    logic             resp_page_fault;
    logic             walk_req;
    logic [VPN_W-1:0] walk_vpn;
    logic             walk_rsp_valid = 1'b0;
    logic             walk_rsp_present = 1'b0;
    logic [PFN_W-1:0] walk_rsp_pfn = '0;
    logic [2:0]       walk_rsp_perm = '0;
    logic             wb_valid;
    logic [VPN_W-1:0] wb_vpn;
    logic             wb_dirty;
    logic             flush_valid = 1'b0;
    logic [VPN_W-1:0] flush_vpn = '0;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    bit  model_on = 1'b0;

    always #5 clk = ~clk;

    fa_tlb #(.ENTRIES(N), .VPN_W(VPN_W), .PFN_W(PFN_W)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_vpn(req_vpn), .req_kind(req_kind),
        .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_pfn(resp_pfn),
        .resp_prot_fault(resp_prot_fault), .resp_page_fault(resp_page_fault),
        .walk_req(walk_req), .walk_vpn(walk_vpn),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_present(walk_rsp_present),
        .walk_rsp_pfn(walk_rsp_pfn), .walk_rsp_perm(walk_rsp_perm),
        .wb_valid(wb_valid), .wb_vpn(wb_vpn), .wb_dirty(wb_dirty),
        .flush_valid(flush_valid), .flush_vpn(flush_vpn)
    );

    // Page table contents, as a function of the page number
    function automatic bit pt_present(logic [VPN_W-1:0] v);
        return v[3:0] != 4'hF;
    endfunction
    function automatic logic [PFN_W-1:0] pt_pfn(logic [VPN_W-1:0] v);
        return PFN_W'(v * 7 + 3);
    endfunction
    function automatic logic [2:0] pt_perm(logic [VPN_W-1:0] v);
        return {(v[2:0] != 3'b110), v[0], v[1]};
    endfunction
    function automatic bit allows(logic [2:0] p, logic [1:0] k);
        if (k == 2'd1) return p[1];
        if (k == 2'd2) return p[0];
        return p[2];
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit               m_v    [N];
    logic [VPN_W-1:0] m_vpn  [N];
    logic [PFN_W-1:0] m_pfn  [N];
    logic [2:0]       m_perm [N];
    bit               m_mod  [N];
    int               m_rr;
    bit               m_walk;
    logic [VPN_W-1:0] m_pvpn;
    logic [1:0]       m_pkind;
    bit               e_rv, e_prot, e_pf, e_wb, e_wbd;
    logic [PFN_W-1:0] e_pfn;
    logic [VPN_W-1:0] e_wbvpn;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin m_v[i] = 0; m_mod[i] = 0; end
            m_rr = 0; m_walk = 0;
            e_rv = 0; e_prot = 0; e_pf = 0; e_wb = 0; e_pfn = '0;
            model_on = 1'b1;
        end else begin
            bit fm [N];
            int ins;
            ins = -1;
            e_rv = 0; e_prot = 0; e_pf = 0; e_pfn = '0; e_wb = 0;
            for (int i = 0; i < N; i++)
                fm[i] = flush_valid && m_v[i] && (m_vpn[i] == flush_vpn);
            if (!m_walk) begin
                if (req_valid) begin
                    int h;
                    h = -1;
                    for (int i = 0; i < N; i++)
                        if (m_v[i] && m_vpn[i] == req_vpn) h = i;
                    if (h >= 0) begin
                        e_rv = 1;
                        if (allows(m_perm[h], req_kind)) begin
                            e_pfn = m_pfn[h];
                            if (req_kind == 2'd1 && !fm[h]) m_mod[h] = 1;
                        end else e_prot = 1;
                    end else begin
                        m_walk = 1; m_pvpn = req_vpn; m_pkind = req_kind;
                    end
                end
            end else if (walk_rsp_valid) begin
                m_walk = 0;
                e_rv = 1;
                if (!walk_rsp_present) e_pf = 1;
                else begin
                    int vic;
                    vic = -1;
                    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vic = i;
                    if (vic < 0) begin
                        vic = m_rr;
                        m_rr = (m_rr + 1) % N;
                    end
                    if (m_v[vic]) begin
                        e_wb = 1; e_wbvpn = m_vpn[vic]; e_wbd = m_mod[vic];
                    end
                    m_v[vic] = 1; m_vpn[vic] = m_pvpn;
                    m_pfn[vic] = walk_rsp_pfn; m_perm[vic] = walk_rsp_perm;
                    m_mod[vic] = (m_pkind == 2'd1) && allows(walk_rsp_perm, m_pkind);
                    ins = vic;
                    if (allows(walk_rsp_perm, m_pkind)) e_pfn = walk_rsp_pfn;
                    else e_prot = 1;
                end
            end
            for (int i = 0; i < N; i++) if (fm[i] && i != ins) m_v[i] = 0;
        end
    end

    // Per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (model_on && !rst && !done) begin
            chk(req_ready == !m_walk, "R5 req_ready", req_ready, !m_walk);
            chk(walk_req == m_walk, "R5 walk_req", walk_req, m_walk);
            if (m_walk) chk(walk_vpn == m_pvpn, "R5 walk_vpn", walk_vpn, m_pvpn);
            chk(resp_valid == e_rv, "R2 R6 resp_valid", resp_valid, e_rv);
            if (e_rv) begin
                chk(resp_pfn == e_pfn, "R6 resp_pfn", resp_pfn, e_pfn);
                chk(resp_prot_fault == e_prot, "R3 prot_fault", resp_prot_fault, e_prot);
                chk(resp_page_fault == e_pf, "R7 page_fault", resp_page_fault, e_pf);
            end
            chk(wb_valid == e_wb, "R8 wb_valid", wb_valid, e_wb);
            if (e_wb) begin
                chk(wb_vpn == e_wbvpn, "R9 wb_vpn", wb_vpn, e_wbvpn);
                chk(wb_dirty == e_wbd, "R4 R9 wb_dirty", wb_dirty, e_wbd);
            end
        end
    end

    // Page-table walker stand-in: answers two cycles after a request
    int wcnt = 0;
    always @(negedge clk) begin
        if (rst || !walk_req || walk_rsp_valid) begin
            walk_rsp_valid = 1'b0;
            wcnt = 0;
        end else begin
            wcnt++;
            if (wcnt == 2) begin
                walk_rsp_valid   = 1'b1;
                walk_rsp_present = pt_present(walk_vpn);
                walk_rsp_pfn     = pt_pfn(walk_vpn);
                walk_rsp_perm    = pt_perm(walk_vpn);
            end
        end
    end

    task automatic lookup(int v, int k, bit fl = 0, int fv = 0);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vpn = VPN_W'(v); req_kind = 2'(k);
        flush_valid = fl; flush_vpn = VPN_W'(fv);
        @(negedge clk);
        req_valid = 1'b0; flush_valid = 1'b0;
    endtask

    task automatic flush_only(int fv);
        flush_valid = 1'b1; flush_vpn = VPN_W'(fv);
        @(negedge clk);
        flush_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(resp_valid == 1'b0, "R1 no response after reset", resp_valid, 0);
        chk(walk_req == 1'b0, "R1 no walk after reset", walk_req, 0);
        chk(wb_valid == 1'b0, "R1 no write-back after reset", wb_valid, 0);

        // Fill all eight slots (R5, R6, R8)
        for (int v = 1; v <= 8; v++) lookup(v, 0);
        // Hits with every access kind (R2, R3, R4)
        for (int v = 1; v <= 8; v++) lookup(v, 1);
        for (int v = 1; v <= 8; v++) lookup(v, 2);
        lookup(6, 0);
        lookup(3, 3);
        // Non-resident page, twice (R7)
        lookup(15, 0);
        lookup(15, 0);
        // Table full: round-robin victims with dirty write-back (R8, R9)
        lookup(9, 1);
        lookup(10, 0);
        // Flush alone, then refill into the freed slot (R10, R8)
        flush_only(3);
        lookup(3, 1);
        // Flush together with a write lookup of the same page (R10)
        lookup(5, 1, 1, 5);
        chk(resp_valid == 1'b1 && resp_page_fault == 1'b0,
            "R10 same-cycle lookup uses old entry", resp_valid, 1);
        lookup(5, 0);
        chk(walk_req == 1'b1, "R10 flushed page misses", walk_req, 1);
        // Flush during a walk (R10)
        lookup(40, 1);
        flush_only(7);
        lookup(7, 0);

        // Random phase with scattered flushes
        for (int n = 0; n < 600; n++) begin
            int v;
            v = 1 + int'($urandom % 24);
            if ($urandom % 5 == 0) lookup(v, int'($urandom % 4), 1, 1 + int'($urandom % 24));
            else lookup(v, int'($urandom % 3));
            if ($urandom % 4 == 0) flush_only(1 + int'($urandom % 24));
        end
        repeat (10) @(negedge clk);
        finish_run();
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            n_checks++;
            n_fail++;
            $display("[TB] FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            finish_run();
        end
    end

endmodule